// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This unit carries out the memory instructions of a 32-bit little-endian RISC core over a single-beat data bus with per-byte enables. When the core pulses a start strobe, the unit takes the instruction word, the base register value and the store data register value. It forms the effective address and decodes the access size, direction and signedness. It then places one request on the bus and holds it until the bus signals ready.

For a store, the low bytes of the data register are copied into every lane of the selected width, and the byte enables pick the lanes that memory actually writes. For a load, the returned word is shifted so the addressed lane sits at bit 0, and is then zero- or sign-extended. One cycle after the response, the unit raises a single-cycle done strobe and offers the result for the destination register field.

Each access size has a normal opcode and an I/O twin that differs only in opcode bit 5. The two behave identically.

Top module: `lsu_lane_unit`

## Requirements
- R1: The bus address equals the base input plus the sign-extended 16-bit immediate in instruction bits [21:6], wrapping modulo 2^32.
- R2: Byte enables are 4'b0001 shifted left by addr[1:0] for byte accesses, 4'b0011 for halfwords with addr[1]=0 and 4'b1100 with addr[1]=1, and 4'b1111 for words.
- R3: Stores (opcode low bits 0x05 byte, 0x0D halfword, 0x15 word) raise the write request only. The write data is {4{rB[7:0]}} for bytes, {2{rB[15:0]}} for halfwords and rB for words. Loads raise the read request only.
- R4: A load takes its data from the byte lane addr[1:0] (byte) or the halfword lane addr[1] (halfword) of the read data. Opcode 0x03 zero-extends a byte and 0x07 sign-extends it, 0x0B zero-extends a halfword and 0x0F sign-extends it, and 0x17 returns the whole word.
- R5: Every opcode with bit 5 set (0x23, 0x25, 0x27, 0x2B, 0x2D, 0x2F, 0x35, 0x37) behaves exactly like its twin with bit 5 clear.
- R6: While the bus does not signal ready, the request stays asserted and the address, byte enables and write data stay unchanged. The read data is ignored in those cycles.
- R7: Done is high for exactly one cycle: the cycle after the one in which ready was seen. For loads it comes with the destination index taken from instruction bits [26:22] and with the load result. For stores it comes with the register write enable low.
- R8: A load whose destination index is 0 completes with done but with the register write enable low.
- R9: A start strobe with an opcode outside the memory set is ignored: no request and no done follow. A start strobe during an access in flight does not disturb it.
- R10: In reset and right after it, the read request, write request, done and register write enable are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin executing the presented instruction |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register (rA) value |
| store_i | input | 32 | Store data register (rB) value |
| bus_addr_o | output | 32 | Effective byte address |
| bus_be_o | output | 4 | Byte-lane enables |
| bus_wdata_o | output | 32 | Lane-replicated write data |
| bus_rd_o | output | 1 | Read request |
| bus_wr_o | output | 1 | Write request |
| bus_ready_i | input | 1 | Bus accepts or answers the request this cycle |
| bus_rdata_i | input | 32 | Read data, valid with ready |
| done_o | output | 1 | One-cycle completion strobe |
| wr_en_o | output | 1 | Register write enable for the destination |
| wr_idx_o | output | 5 | Destination register index |
| wr_data_o | output | 32 | Load result |

## Verification
The bench sweeps all sixteen memory opcodes over all four low address offsets. It uses three read-data patterns whose bytes have the sign bit set and clear in different lanes, so that zero- and sign-extension give different answers and picking the wrong lane changes the result. Three base and immediate pairs are used: a negative immediate, a positive immediate, and one whose sum wraps past 2^32. Together they separate correct immediate extension from truncation. Zero, one and two wait states are mixed in, with garbage on the read data and a stray start strobe while the bus is stalled. A destination index of zero and a set of non-memory opcodes show that the write is suppressed and that foreign starts are dropped.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_RESP = 2'd2
    } lsu_state_e;

    typedef struct packed {
        logic      valid;
        logic      is_load;
        logic      sign_ext;
        acc_size_e size;
    } mem_op_t;

    // instruction field positions (fixed by the instruction encoding)
    localparam int INSTR_W    = 32;
    localparam int OPC_BASE_W = 5;   // opcode bits below the I/O-twin bit
    localparam int IMM_LSB    = 6;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [OPC_BASE_W-1:0] opcode_i,
    output mem_op_t               op_o
);

    // bit 5 of the opcode never reaches this decoder, so twins decode alike
    always_comb begin
        op_o = '0;
        case (opcode_i)
            5'h03: begin op_o.valid = 1'b1; op_o.is_load = 1'b1; op_o.size = SZ_BYTE; end
            5'h07: begin op_o.valid = 1'b1; op_o.is_load = 1'b1; op_o.sign_ext = 1'b1;
                         op_o.size = SZ_BYTE; end
            5'h0B: begin op_o.valid = 1'b1; op_o.is_load = 1'b1; op_o.size = SZ_HALF; end
            5'h0F: begin op_o.valid = 1'b1; op_o.is_load = 1'b1; op_o.sign_ext = 1'b1;
                         op_o.size = SZ_HALF; end
            5'h17: begin op_o.valid = 1'b1; op_o.is_load = 1'b1; op_o.size = SZ_WORD; end
            5'h05: begin op_o.valid = 1'b1; op_o.size = SZ_BYTE; end
            5'h0D: begin op_o.valid = 1'b1; op_o.size = SZ_HALF; end
            5'h15: begin op_o.valid = 1'b1; op_o.size = SZ_WORD; end
            default: op_o = '0;
        endcase
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter  int DATA_W    = 32,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int LANE_W    = $clog2(NUM_LANES)
) (
    input  acc_size_e             size_i,
    input  logic [LANE_W-1:0]     offset_i,
    input  logic [DATA_W-1:0]     data_i,
    output logic [NUM_LANES-1:0]  be_o,
    output logic [DATA_W-1:0]     lanes_o
);

    always_comb begin
        case (size_i)
            SZ_BYTE: be_o = NUM_LANES'(1) << offset_i;
            SZ_HALF: be_o = NUM_LANES'(3) << {offset_i[LANE_W-1:1], 1'b0};
            default: be_o = '1;
        endcase
    end

    // each lane carries the byte of the source that lands in it
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        assign lanes_o[8*k +: 8] =
            (size_i == SZ_BYTE) ? data_i[7:0] :
            (size_i == SZ_HALF) ? data_i[8*(k%2) +: 8] :
                                  data_i[8*k +: 8];
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANE_W = $clog2(DATA_W / 8)
) (
    input  acc_size_e          size_i,
    input  logic               sign_ext_i,
    input  logic [LANE_W-1:0]  offset_i,
    input  logic [DATA_W-1:0]  raw_i,
    output logic [DATA_W-1:0]  value_o
);

    logic [LANE_W-1:0] lane;
    logic [LANE_W+2:0] shamt;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        case (size_i)
            SZ_BYTE: lane = offset_i;
            SZ_HALF: lane = {offset_i[LANE_W-1:1], 1'b0};
            default: lane = '0;
        endcase
        shamt   = {lane, 3'b000};
        shifted = raw_i >> shamt;
        case (size_i)
            SZ_BYTE: value_o = {{(DATA_W-8){sign_ext_i & shifted[7]}}, shifted[7:0]};
            SZ_HALF: value_o = {{(DATA_W-16){sign_ext_i & shifted[15]}}, shifted[15:0]};
            default: value_o = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter  int ADDR_W    = 32,
    parameter  int DATA_W    = 32,
    parameter  int IMM_W     = 16,
    parameter  int IDX_W     = 5,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int LANE_W    = $clog2(NUM_LANES),
    localparam int IDX_LSB   = IMM_LSB + IMM_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [INSTR_W-1:0]    instr_i,
    input  logic [DATA_W-1:0]     base_i,
    input  logic [DATA_W-1:0]     store_i,
    output logic [ADDR_W-1:0]     bus_addr_o,
    output logic [NUM_LANES-1:0]  bus_be_o,
    output logic [DATA_W-1:0]     bus_wdata_o,
    output logic                  bus_rd_o,
    output logic                  bus_wr_o,
    input  logic                  bus_ready_i,
    input  logic [DATA_W-1:0]     bus_rdata_i,
    output logic                  done_o,
    output logic                  wr_en_o,
    output logic [IDX_W-1:0]      wr_idx_o,
    output logic [DATA_W-1:0]     wr_data_o
);

    typedef struct packed {
        lsu_state_e             state;
        logic [ADDR_W-1:0]      addr;
        logic [NUM_LANES-1:0]   be;
        logic [DATA_W-1:0]      wdata;
        logic                   is_load;
        logic                   sign_ext;
        acc_size_e              size;
        logic [IDX_W-1:0]       idx;
        logic [DATA_W-1:0]      result;
    } lsu_regs_t;

    lsu_regs_t r_d, r_q;

    // ---------------- instruction fields ----------------
    mem_op_t             dec_op;
    logic [IMM_W-1:0]    imm;
    logic [ADDR_W-1:0]   imm_sext;
    logic [ADDR_W-1:0]   eff_addr;
    logic                unused_fields;

    assign imm           = instr_i[IMM_LSB +: IMM_W];
    assign imm_sext      = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign eff_addr      = ADDR_W'(base_i) + imm_sext;
    assign unused_fields = ^{instr_i[INSTR_W-1:IDX_LSB+IDX_W], instr_i[OPC_BASE_W]};

    lsu_decode u_dec (
        .opcode_i (instr_i[OPC_BASE_W-1:0]),
        .op_o     (dec_op)
    );

    // ---------------- lane steering ----------------
    logic [NUM_LANES-1:0] be_c;
    logic [DATA_W-1:0]    wdata_c;
    logic [DATA_W-1:0]    load_val;

    lsu_store_lanes #(.DATA_W(DATA_W)) u_st (
        .size_i   (dec_op.size),
        .offset_i (eff_addr[LANE_W-1:0]),
        .data_i   (store_i),
        .be_o     (be_c),
        .lanes_o  (wdata_c)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
        .size_i     (r_q.size),
        .sign_ext_i (r_q.sign_ext),
        .offset_i   (r_q.addr[LANE_W-1:0]),
        .raw_i      (bus_rdata_i),
        .value_o    (load_val)
    );

    // ---------------- next-state ----------------
    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i && dec_op.valid) begin
                    r_d.state    = ST_BUS;
                    r_d.addr     = eff_addr;
                    r_d.be       = be_c;
                    r_d.wdata    = wdata_c;
                    r_d.is_load  = dec_op.is_load;
                    r_d.sign_ext = dec_op.sign_ext;
                    r_d.size     = dec_op.size;
                    r_d.idx      = instr_i[IDX_LSB +: IDX_W];
                end
            end
            ST_BUS: begin
                if (bus_ready_i) begin
                    r_d.state  = ST_RESP;
                    r_d.result = r_q.is_load ? load_val : '0;
                end
            end
            ST_RESP: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // ---------------- outputs ----------------
    assign bus_addr_o  = r_q.addr;
    assign bus_be_o    = r_q.be;
    assign bus_wdata_o = r_q.wdata;
    assign bus_rd_o    = (r_q.state == ST_BUS) &&  r_q.is_load;
    assign bus_wr_o    = (r_q.state == ST_BUS) && !r_q.is_load;
    assign done_o      = (r_q.state == ST_RESP);
    assign wr_en_o     = done_o && r_q.is_load && (r_q.idx != '0);
    assign wr_idx_o    = r_q.idx;
    assign wr_data_o   = r_q.result;

    // ---------------- assertions ----------------
    logic bus_req;
    assign bus_req = bus_rd_o | bus_wr_o;

    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready_i) |=> (bus_req && $stable(bus_addr_o) &&
                                       $stable(bus_be_o) && $stable(bus_wdata_o)));

    a_r7_done_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready_i) |=> (done_o && !bus_req));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (done_o && wr_idx_o != '0));

    a_r2_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_be_o) == 1 || $countones(bus_be_o) == 2 ||
                     $countones(bus_be_o) == NUM_LANES));

    a_r9_foreign_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_req && !done_o && start_i && !dec_op.valid) |=> !bus_req);

endmodule

// File: tb/lsu_lane_unit_test.sv
module lsu_lane_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] instr_i;
    logic [31:0] base_i;
    logic [31:0] store_i;
    logic [31:0] bus_addr_o;
    logic [3:0]  bus_be_o;
    logic [31:0] bus_wdata_o;
    logic        bus_rd_o;
    logic        bus_wr_o;
    logic        bus_ready_i;
    logic [31:0] bus_rdata_i;
    logic        done_o;
    logic        wr_en_o;
    logic [4:0]  wr_idx_o;
    logic [31:0] wr_data_o;

    lsu_lane_unit uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .base_i(base_i), .store_i(store_i), .bus_addr_o(bus_addr_o),
        .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o), .bus_rd_o(bus_rd_o),
        .bus_wr_o(bus_wr_o), .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i),
        .done_o(done_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---- reference model from the requirements ----
    function automatic logic ref_is_load(input logic [5:0] op);
        return op[4:0] inside {5'h03, 5'h07, 5'h0B, 5'h0F, 5'h17};
    endfunction

    function automatic int ref_size(input logic [5:0] op);
        if (op[4:0] inside {5'h03, 5'h05, 5'h07}) return 1;
        if (op[4:0] inside {5'h0B, 5'h0D, 5'h0F}) return 2;
        return 4;
    endfunction

    function automatic logic [3:0] ref_be(input int sz, input logic [1:0] off);
        if (sz == 1) return 4'b0001 << off;
        if (sz == 2) return off[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] ref_wdata(input int sz, input logic [31:0] d);
        if (sz == 1) return {4{d[7:0]}};
        if (sz == 2) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] ref_load(input logic [5:0] op, input logic [31:0] raw,
                                             input logic [1:0] off);
        logic [31:0] s;
        logic        sgn;
        sgn = op[4:0] inside {5'h07, 5'h0F};
        if (ref_size(op) == 1) begin
            s = raw >> (8 * off);
            return sgn ? {{24{s[7]}}, s[7:0]} : {24'h0, s[7:0]};
        end
        if (ref_size(op) == 2) begin
            s = raw >> (off[1] ? 16 : 0);
            return sgn ? {{16{s[15]}}, s[15:0]} : {16'h0, s[15:0]};
        end
        return raw;
    endfunction

    task automatic run_access(input logic [5:0] op, input logic [31:0] base,
                              input logic [15:0] imm, input logic [4:0] idx,
                              input logic [31:0] sdata, input logic [31:0] rdata,
                              input int waits);
        logic [31:0] ea;
        logic [1:0]  off;
        logic        ld;
        int          sz;
        string       p;
        ea  = base + {{16{imm[15]}}, imm};
        off = ea[1:0];
        ld  = ref_is_load(op);
        sz  = ref_size(op);
        p   = $sformatf("%sop=%h off=%0d", op[5] ? "R5 " : "", op, off);

        @(negedge clk);
        start_i = 1'b1;
        instr_i = {5'd9, idx, imm, op};
        base_i  = base;
        store_i = sdata;
        @(negedge clk);
        start_i = 1'b0;
        chk({"R3 rd ", p}, {31'h0, bus_rd_o}, {31'h0, ld});
        chk({"R3 wr ", p}, {31'h0, bus_wr_o}, {31'h0, !ld});
        chk({"R1 addr ", p}, bus_addr_o, ea);
        chk({"R2 be ", p}, {28'h0, bus_be_o}, {28'h0, ref_be(sz, off)});
        if (!ld) chk({"R3 wdata ", p}, bus_wdata_o, ref_wdata(sz, sdata));

        for (int w = 0; w < waits; w++) begin
            bus_ready_i = 1'b0;
            bus_rdata_i = ~rdata;
            if (w == 0) begin
                start_i = 1'b1;
                instr_i = {5'd2, 5'd7, 16'h0040, 6'h17};
                base_i  = 32'h1234_5678;
                store_i = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            start_i = 1'b0;
            chk({"R6 held ", p}, {31'h0, bus_rd_o | bus_wr_o}, 32'h1);
            chk({"R9 R6 addr ", p}, bus_addr_o, ea);
            chk({"R6 be ", p}, {28'h0, bus_be_o}, {28'h0, ref_be(sz, off)});
            if (!ld) chk({"R6 wdata ", p}, bus_wdata_o, ref_wdata(sz, sdata));
            chk({"R7 early done ", p}, {31'h0, done_o}, 32'h0);
        end

        bus_ready_i = 1'b1;
        bus_rdata_i = rdata;
        @(negedge clk);
        bus_ready_i = 1'b0;
        bus_rdata_i = 32'h0BAD_F00D;
        chk({"R7 done ", p}, {31'h0, done_o}, 32'h1);
        chk({"R8 wr_en ", p}, {31'h0, wr_en_o}, {31'h0, ld && (idx != 5'd0)});
        if (ld) begin
            chk({"R7 idx ", p}, {27'h0, wr_idx_o}, {27'h0, idx});
            chk({"R4 data ", p}, wr_data_o, ref_load(op, rdata, off));
        end
        @(negedge clk);
        chk({"R7 done drop ", p}, {31'h0, done_o}, 32'h0);
        chk({"R7 idle ", p}, {30'h0, bus_rd_o, bus_wr_o}, 32'h0);
    endtask

    logic [5:0]  base_ops [0:7];
    logic [31:0] pats     [0:2];

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        base_ops = '{6'h03, 6'h07, 6'h0B, 6'h0F, 6'h17, 6'h05, 6'h0D, 6'h15};
        pats     = '{32'h80FF_7F01, 32'h7F80_01FE, 32'hA5C3_5A3C};
        rst_n       = 1'b0;
        start_i     = 1'b0;
        instr_i     = '0;
        base_i      = '0;
        store_i     = '0;
        bus_ready_i = 1'b0;
        bus_rdata_i = '0;

        repeat (3) @(negedge clk);
        chk("R10 in reset", {28'h0, bus_rd_o, bus_wr_o, done_o, wr_en_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", {28'h0, bus_rd_o, bus_wr_o, done_o, wr_en_o}, 32'h0);

        for (int t = 0; t < 2; t++)
            for (int b = 0; b < 8; b++)
                for (int off = 0; off < 4; off++)
                    for (int p = 0; p < 3; p++) begin
                        logic [31:0] base;
                        logic [15:0] imm;
                        logic [4:0]  idx;
                        logic [31:0] rd;
                        case (p)
                            0:       begin base = 32'h2000_0040 + off; imm = 16'hFFFC; end
                            1:       begin base = 32'h0001_1230 + off; imm = 16'h0104; end
                            default: begin base = 32'hFFFF_FFF0 + off; imm = 16'h0014; end
                        endcase
                        idx = (p == 0 && off == 3) ? 5'd0 : 5'(off * 7 + p + 1);
                        rd  = pats[(p + off) % 3];
                        run_access(base_ops[b] | 6'(t << 5), base, imm, idx,
                                   ~rd + 32'(off), rd, (off + p) % 3);
                    end

        begin
            logic [5:0] foreign [0:5];
            foreign = '{6'h04, 6'h3A, 6'h00, 6'h06, 6'h33, 6'h1C};
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                start_i = 1'b1;
                instr_i = {5'd3, 5'd4, 16'h0010, foreign[i]};
                @(negedge clk);
                start_i = 1'b0;
                chk($sformatf("R9 no req op=%h", foreign[i]),
                    {30'h0, bus_rd_o, bus_wr_o}, 32'h0);
                @(negedge clk);
                chk($sformatf("R9 no done op=%h", foreign[i]),
                    {30'h0, done_o, bus_rd_o | bus_wr_o}, 32'h0);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule